// File: doc/BRIEF.md
# DMA Task Interrupt Aggregator

This block merges the completion events of sixteen DMA tasks into one interrupt request, which the interrupt controller sees as source 0 of its peripheral group. Each task owns one bit in a pending register and one bit in a mask register. A single-cycle event pulse from a task latches its pending bit. The aggregated request is raised while any latched task is also enabled.

When software services the shared interrupt, it uses the reported task identifier to decide which task to handle first. The identifier names the lowest-numbered latched task. It is formed as the group code 3 placed above a 6-bit task field, so that each task has its own interrupt number. Software clears pending bits by writing ones to them, and it sets the mask register with a plain write. Both registers are reached through a simple word-addressed write/read port whose read data is registered.

Top module: `dma_task_irq_agg`

## Requirements
- R1: After reset the pending register reads 0, the mask register reads 0xFFFF (all tasks disabled), and both the request and the identifier-valid output are low.
- R2: A pulse on task event bit n sets pending bit n in the next cycle, whatever the mask bit n holds.
- R3: Writing to the pending register (word address 0) clears every pending bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: If an event for task n and a write that clears pending bit n fall in the same cycle, pending bit n ends up set.
- R5: Writing to the mask register (word address 1) loads bits 15:0 of the write data, and a read returns that value. A mask bit of 1 disables task n.
- R6: The request output is high exactly when some task has its pending bit set and its mask bit clear.
- R7: When any pending bit is set, the identifier-valid output is high and the identifier equals 0xC0 OR n, where n is the lowest-numbered set pending bit. The mask is not taken into account in this choice.
- R8: Read data appears in the cycle after the read strobe. Bits 31:16 of both registers read as zero. A read of any other address returns 0, and a write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| task_evt | input | 16 | One-cycle completion pulses, bit n for task n |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address: 0 pending, 1 mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Aggregated request to the peripheral group |
| sel_valid | output | 1 | At least one task is pending |
| sel_id | output | 8 | Identifier of the selected task: 0xC0 OR task number |

## Verification
The hardest case to reach from the ports is a task event and a clear of the same bit landing on the same clock edge. To create it, the bench drives an event pulse and a write-one-to-clear of that bit on the same falling edge, and then reads the register back. A second hard case is telling the mask-blind selection apart from the mask-gated request. For this, the bench leaves a low-numbered task pending but masked while a higher task is enabled, and shows that the identifier follows the pending bits while the request follows only the enabled ones.

// File: rtl/dtia_pkg.sv
// Package: shared register-select type and grouping constants for the
// DMA task interrupt aggregator.
package dtia_pkg;
    // Which register a bus access targets
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    // Group code placed above the task field of the identifier
    localparam int unsigned GROUP_CODE_DEF  = 3;
    // Bit position of the group code within the identifier
    localparam int unsigned GROUP_SHIFT_DEF = 6;
endpackage

// File: rtl/dtia_addr_decode.sv
// Decodes a bus word address into a register select.
// Assumes the two register addresses differ; every other address maps to none.
module dtia_addr_decode
    import dtia_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned PEND_ADDR = 0,
    parameter int unsigned MASK_ADDR = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Map the address onto one of the registers
    always_comb begin
        if (addr == ADDR_W'(PEND_ADDR))      sel = SEL_PEND;
        else if (addr == ADDR_W'(MASK_ADDR)) sel = SEL_MASK;
        else                                 sel = SEL_NONE;
    end
endmodule

// File: rtl/dtia_pend_bank.sv
// Pending bits: each bit is set by its task event and cleared by a write of 1.
// Assumes clr_vec is already qualified by a write to the pending address.
// If a set and a clear hit the same bit in one cycle, the set wins.
module dtia_pend_bank #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend_q
);
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_bit
            // Per-bit update with the set taking priority over the clear
            always_ff @(posedge clk) begin
                if (!rst_n)          pend_q[gi] <= 1'b0;
                else if (evt[gi])    pend_q[gi] <= 1'b1;
                else if (clr_vec[gi]) pend_q[gi] <= 1'b0;
            end
        end
    endgenerate

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((pend_q & $past(evt)) == $past(evt)));                     // R2
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & clr_vec)) |=> ((pend_q & $past(evt & clr_vec)) == $past(evt & clr_vec))); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0) |=> ((pend_q & $past(clr_vec)) == '0));                    // R3
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));      // R3
endmodule

// File: rtl/dtia_mask_bank.sv
// Mask register: 1 disables a task. It comes out of reset with all ones and
// is loaded whole by a write to its address.
module dtia_mask_bank #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] load_val,
    output logic [N-1:0] mask_q
);
    // Hold the mask; reset to all tasks disabled
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '1;
        else if (load) mask_q <= load_val;
    end

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mask_q == $past(load_val)));                                 // R5
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mask_q));                                            // R5
endmodule

// File: rtl/dtia_lowest_sel.sv
// Find-first-set: returns the index of the lowest set bit and a valid flag.
// Assumes IDX_W is wide enough to hold N-1.
module dtia_lowest_sel #(
    parameter int unsigned N     = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    // Scan from the top down so that the lowest set bit is written last
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_task_irq_agg.sv
// Top of the DMA task interrupt aggregator. It latches task completion
// events, gates them with a mask into one request, names the lowest pending
// task, and exposes both registers on a word-addressed port whose read data
// is registered. Assumes DATA_W > NUM_TASKS and GROUP_SHIFT >= log2(NUM_TASKS).
module dma_task_irq_agg
    import dtia_pkg::*;
#(
    parameter int unsigned NUM_TASKS   = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned PEND_ADDR   = 0,
    parameter int unsigned MASK_ADDR   = 1,
    parameter int unsigned GROUP_CODE  = GROUP_CODE_DEF,
    parameter int unsigned GROUP_SHIFT = GROUP_SHIFT_DEF,
    localparam int unsigned IDX_W      = $clog2(NUM_TASKS),
    localparam int unsigned ID_W       = GROUP_SHIFT + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TASKS-1:0] task_evt,
    input  logic                 bus_wr_en,
    input  logic                 bus_rd_en,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_req,
    output logic                 sel_valid,
    output logic [ID_W-1:0]      sel_id
);
    reg_sel_e             sel;
    logic [NUM_TASKS-1:0] pend_q;
    logic [NUM_TASKS-1:0] mask_q;
    logic [NUM_TASKS-1:0] clr_vec;
    logic [IDX_W-1:0]     sel_idx;
    logic                 mask_load;
    logic [DATA_W-1:0]    rdata_q;

    generate
        if (DATA_W > NUM_TASKS) begin : g_hi
            logic wdata_hi_unused;
            // Upper write-data bits have no storage
            assign wdata_hi_unused = ^bus_wdata[DATA_W-1:NUM_TASKS];
        end
    endgenerate

    dtia_addr_decode #(
        .ADDR_W(ADDR_W), .PEND_ADDR(PEND_ADDR), .MASK_ADDR(MASK_ADDR)
    ) u_dec (
        .addr(bus_addr), .sel(sel)
    );

    // Qualify write strobes per register
    always_comb begin
        clr_vec   = (bus_wr_en && sel == SEL_PEND) ? bus_wdata[NUM_TASKS-1:0] : '0;
        mask_load = bus_wr_en && (sel == SEL_MASK);
    end

    dtia_pend_bank #(.N(NUM_TASKS)) u_pend (
        .clk(clk), .rst_n(rst_n), .evt(task_evt), .clr_vec(clr_vec), .pend_q(pend_q)
    );

    dtia_mask_bank #(.N(NUM_TASKS)) u_mask (
        .clk(clk), .rst_n(rst_n), .load(mask_load),
        .load_val(bus_wdata[NUM_TASKS-1:0]), .mask_q(mask_q)
    );

    dtia_lowest_sel #(.N(NUM_TASKS), .IDX_W(IDX_W)) u_sel (
        .vec(pend_q), .idx(sel_idx), .found(sel_valid)
    );

    // Aggregated request and group-tagged identifier
    always_comb begin
        irq_req = |(pend_q & ~mask_q);
        sel_id  = ID_W'(GROUP_CODE << GROUP_SHIFT) | ID_W'(sel_idx);
    end

    // Registered read mux; unmapped addresses return zero
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (bus_rd_en) begin
            case (sel)
                SEL_PEND: rdata_q <= DATA_W'(pend_q);
                SEL_MASK: rdata_q <= DATA_W'(mask_q);
                default:  rdata_q <= '0;
            endcase
        end
    end
    assign bus_rdata = rdata_q;

    AST_REQ_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((pend_q & ~mask_q) != '0));                              // R6
    AST_SEL_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> pend_q[sel_idx]);                                        // R7
    AST_SEL_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> ((pend_q & ~({NUM_TASKS{1'b1}} << sel_idx)) == '0));     // R7
    AST_READ_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_TASKS] == '0);                                  // R8
endmodule

// File: tb/dma_task_irq_agg_bench.sv
`timescale 1ns/1ps
module dma_task_irq_agg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] task_evt = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic        sel_valid;
    logic [7:0]  sel_id;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    dma_task_irq_agg u_dma_task_irq_agg (
        .clk(clk), .rst_n(rst_n), .task_evt(task_evt),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .sel_valid(sel_valid), .sel_id(sel_id)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: a read strobe seen at a rising edge yields data by the next falling edge
    always @(posedge clk) rd_seen <= bus_rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    // Driver: push the expected value, then issue the read
    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic pulse(logic [15:0] v);
        task_evt = v;
        @(negedge clk);
        task_evt = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", irq_req, 0);
        check("R1 sel_valid", sel_valid, 0);
        rd(0, 32'h0, "R1 pending");
        rd(1, 32'hFFFF, "R1 mask");

        // R2 event latches while masked; R6 request stays low; R7 id
        pulse(16'h0020);
        check("R6 masked no irq", irq_req, 0);
        check("R7 valid", sel_valid, 1);
        check("R7 id task5", sel_id, 8'hC5);
        rd(0, 32'h20, "R2 pending");

        // R5 mask write, R6 request rises
        wr(1, 32'h0000_FFDF);
        rd(1, 32'hFFDF, "R5 mask");
        check("R6 irq on", irq_req, 1);

        // R7 lowest wins
        pulse(16'h0208);
        check("R7 id task3", sel_id, 8'hC3);
        check("R6 irq only via 5", irq_req, 1);
        rd(0, 32'h228, "R2 pending multi");

        // R3 write one clears, zero keeps
        wr(0, 32'h0000_0008);
        rd(0, 32'h220, "R3 w1c");
        check("R7 id back to 5", sel_id, 8'hC5);
        wr(0, 32'h0);
        rd(0, 32'h220, "R3 w0 keeps");

        // R4 set and clear of bit 9 together, clear of bit 5 alone
        task_evt = 16'h0200; bus_wr_en = 1'b1; bus_addr = 0; bus_wdata = 32'h220;
        @(negedge clk);
        task_evt = '0; bus_wr_en = 1'b0; bus_wdata = '0;
        rd(0, 32'h200, "R4 set wins");
        check("R6 masked 9 only", irq_req, 0);
        check("R7 id task9", sel_id, 8'hC9);

        // R7 boundaries 15 and 0
        pulse(16'h8000);
        check("R7 id still 9", sel_id, 8'hC9);
        pulse(16'h0001);
        check("R7 id task0", sel_id, 8'hC0);
        wr(0, 32'hFFFF_FFFF);
        check("R7 none valid", sel_valid, 0);
        check("R6 none irq", irq_req, 0);

        // R8 unmapped address and upper bits
        wr(2, 32'h0000_0000);
        rd(1, 32'hFFDF, "R8 unmapped write ignored");
        rd(2, 32'h0, "R8 unmapped read");
        wr(1, 32'hFFFF_0000);
        rd(1, 32'h0, "R8 upper bits zero");
        pulse(16'h8000);
        check("R6 irq task15", irq_req, 1);
        check("R7 id task15", sel_id, 8'hCF);

        // R1 reset mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", irq_req, 0);
        rd(1, 32'hFFFF, "R1 mask after reset");
        rd(0, 32'h0, "R1 pending after reset");
        @(negedge clk);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule